// File: doc/BRIEF.md
# Power Button Event Controller

This block turns an active-low mechanical power button into clean power-management events. The raw pin is brought into the clock domain by a two-stage synchronizer. A counter-based filter then accepts a new level only after the level has held for a full debounce interval. The filtered level is exported as a status bit, where 1 means the button is held, so software can see whether the button is still down.

Every event is keyed to the filtered press edge and never to the release. When the system is running (S0), a press raises a one-cycle software notification as either an SCI or an SMI, selected by four enable inputs. When the system is suspended (S1 to S5), a press raises a one-cycle wake request instead. A press during a suspend-stretch window gives no wake. While the system stays in S0, a separate hold timer measures how long the button stays down. Once the limit is reached, the timer issues a single power-off request that waits for no acknowledgement from any other agent.

With main power absent, the button is ignored completely. The surrounding sleep-state sequencer supplies the state code and the stretch flag and consumes the pulses. Both durations are parameters counted in clock cycles.

Top module: `pwrbtn_event_ctrl`

## Requirements
- R1: `btn_level` goes high exactly DEB_CYC+2 clock edges after `btn_raw_n` goes low and stays low. It goes low exactly DEB_CYC+2 edges after the pin goes high and stays high. `btn_level` is 1 while the button is held.
- R2: A pin pulse in either direction that lasts fewer than DEB_CYC-1 cycles leaves `btn_level` unchanged and raises no event.
- R3: In state code 0 (S0), the edge after `btn_level` rises drives exactly one one-cycle pulse on one output. `sci_evt` is chosen when `sci_en` and `btn_en` are both 1. `smi_evt` is chosen when `sci_en` is 0, `glb_smi_en` is 1 and at least one of `btn_en` and `btn_init_en` is 1. For any other enable combination, no pulse is raised.
- R4: Holding the button and releasing it raise no further SMI, SCI or wake pulse.
- R5: In state codes 1 to 5 (S1 to S5) with `stretch_active` at 0, a press raises one `wake_evt` pulse and no SMI or SCI.
- R6: While `stretch_active` is 1, a press raises no wake, and the hold timer is held at zero. After the flag drops with the button still held in S0, `force_off` pulses exactly LONG_CYC edges later.
- R7: For state codes 6 and 7 (no main power), `btn_level` stays 0 and no pulse of any kind is raised.
- R8: In S0, after `btn_level` has been 1 for LONG_CYC consecutive sampled cycles, `force_off` pulses for one cycle. It pulses only once per continuous press, however long the hold lasts.
- R9: The hold timer counts only in S0 and restarts from zero on release. A hold in a suspend state never raises `force_off`. A hold that carries over into S0 raises `force_off` LONG_CYC edges after S0 is entered. A press shorter than LONG_CYC raises no `force_off`, and the next press again needs the full LONG_CYC.
- R10: While `rst` is high and right after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw_n | input | 1 | Asynchronous button pin, low when pressed |
| sleep_st | input | 3 | Sleep state: 0=S0, 1..5=S1..S5, 6 and 7=no main power |
| stretch_active | input | 1 | Minimum-width stretch of the S4 sleep signal is in progress |
| sci_en | input | 1 | Route the notification as SCI |
| btn_en | input | 1 | Button event enable |
| btn_init_en | input | 1 | Button SMI enable, used when the event enable is clear |
| glb_smi_en | input | 1 | Global SMI enable |
| btn_level | output | 1 | Filtered button level, 1 = held |
| smi_evt | output | 1 | One-cycle SMI request |
| sci_evt | output | 1 | One-cycle SCI request |
| wake_evt | output | 1 | One-cycle wake request |
| force_off | output | 1 | One-cycle unconditional power-off request |

## Verification
A wrong debounce count shows up at `btn_level` as a rise or fall that comes one or more edges off the DEB_CYC+2 point. Each press is timed to the exact edge. A stale edge-detect register shows up within one cycle as a missing pulse, a doubled pulse or a release-triggered pulse. A hold counter that fails to clear, or that runs outside S0 or during a stretch, shows up as a `force_off` pulse that is early, late, repeated or missing. The bench measures the distance from the press, from the stretch drop and from the entry into S0 to the edge where `force_off` appears.

// File: rtl/pbe_pkg.sv
package pbe_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_SL1  = 3'd1,
    ST_SL2  = 3'd2,
    ST_SL3  = 3'd3,
    ST_SL4  = 3'd4,
    ST_SL5  = 3'd5,
    ST_NOPA = 3'd6,
    ST_NOPB = 3'd7
  } slp_state_e;

  function automatic logic st_is_run(input logic [2:0] s);
    return s == ST_RUN;
  endfunction

  function automatic logic st_is_susp(input logic [2:0] s);
    return (s >= ST_SL1) && (s <= ST_SL5);
  endfunction

  function automatic logic st_no_power(input logic [2:0] s);
    return s >= ST_NOPA;
  endfunction

  typedef struct packed {
    logic smi;
    logic sci;
    logic wake;
  } btn_evt_t;

endpackage

// File: rtl/pbe_sync_debounce.sv
module pbe_sync_debounce #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 524
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic raw_n,
  output logic pressed
);
  localparam int CW = $clog2(DEB_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_lvl;
  logic [CW-1:0]          stab_cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ~raw_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ~raw_n};
      end
    end
  endgenerate

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      stab_cnt <= '0;
      pressed  <= 1'b0;
    end else if (sync_lvl == pressed) begin
      stab_cnt <= '0;
    end else if (stab_cnt == CW'(DEB_CYC - 1)) begin
      stab_cnt <= '0;
      pressed  <= sync_lvl;
    end else begin
      stab_cnt <= stab_cnt + 1'b1;
    end
  end

  // R1: a change of the filtered level always adopts the synchronized level
  p_deb_follows_sync_r1: assert property (@(posedge clk) disable iff (rst)
    (pressed != $past(pressed)) && !$past(clr) |-> $past(sync_lvl) == pressed);

  // R2: the level only changes after the stability counter has run out
  p_deb_full_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (pressed != $past(pressed)) && !$past(clr) |-> $past(stab_cnt) == CW'(DEB_CYC - 1));

endmodule

// File: rtl/pbe_event_route.sv
module pbe_event_route
  import pbe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pressed,
  input  logic [2:0] sleep_st,
  input  logic       stretch_active,
  input  logic       sci_en,
  input  logic       btn_en,
  input  logic       btn_init_en,
  input  logic       glb_smi_en,
  output btn_evt_t   evt
);
  logic     prev_q;
  logic     edge_w;
  btn_evt_t evt_d;

  assign edge_w = pressed & ~prev_q;

  always_comb begin
    evt_d = '0;
    if (edge_w) begin
      if (st_is_run(sleep_st)) begin
        evt_d.sci = sci_en & btn_en;
        evt_d.smi = ~sci_en & glb_smi_en & (btn_en | btn_init_en);
      end else if (st_is_susp(sleep_st)) begin
        evt_d.wake = ~stretch_active;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      evt    <= '0;
    end else begin
      prev_q <= pressed;
      evt    <= evt_d;
    end
  end

  // R5: at most one kind of event in any cycle
  p_evt_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt.smi, evt.sci, evt.wake}));

  // R4: a press yields a single pulse, never two cycles in a row
  p_no_repeat_r4: assert property (@(posedge clk) disable iff (rst)
    (evt.smi | evt.sci | evt.wake) |=> !(evt.smi | evt.sci | evt.wake));

  // R5: wake only from a suspend state outside a stretch
  p_wake_susp_r5: assert property (@(posedge clk) disable iff (rst)
    evt.wake |-> $past(st_is_susp(sleep_st) && !stretch_active));

  // R3: software notifications only from the running state
  p_notify_run_r3: assert property (@(posedge clk) disable iff (rst)
    (evt.smi | evt.sci) |-> $past(st_is_run(sleep_st)));

endmodule

// File: rtl/pbe_long_press.sv
module pbe_long_press #(
  parameter int LONG_CYC = 131072
) (
  input  logic clk,
  input  logic rst,
  input  logic pressed,
  input  logic run_ok,
  output logic force_off
);
  localparam int CW = $clog2(LONG_CYC + 1);

  logic [CW-1:0] hold_cnt;
  logic          fired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt  <= '0;
      fired_q   <= 1'b0;
      force_off <= 1'b0;
    end else begin
      force_off <= 1'b0;
      if (!pressed) begin
        hold_cnt <= '0;
        fired_q  <= 1'b0;
      end else if (!run_ok) begin
        hold_cnt <= '0;
      end else if (!fired_q) begin
        if (hold_cnt == CW'(LONG_CYC - 1)) begin
          force_off <= 1'b1;
          fired_q   <= 1'b1;
          hold_cnt  <= '0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end
    end
  end

  // R8: the request is a single-cycle pulse
  p_off_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    force_off |=> !force_off);

  // R9: the request only follows a held button in a running, unstretched state
  p_off_in_run_r9: assert property (@(posedge clk) disable iff (rst)
    force_off |-> $past(pressed && run_ok));

  // R6: a stretch keeps the timer cleared
  p_stretch_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!run_ok) |-> hold_cnt == '0);

endmodule

// File: rtl/pwrbtn_event_ctrl.sv
module pwrbtn_event_ctrl
  import pbe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 524,
  parameter int LONG_CYC    = 131072
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_raw_n,
  input  logic [2:0] sleep_st,
  input  logic       stretch_active,
  input  logic       sci_en,
  input  logic       btn_en,
  input  logic       btn_init_en,
  input  logic       glb_smi_en,
  output logic       btn_level,
  output logic       smi_evt,
  output logic       sci_evt,
  output logic       wake_evt,
  output logic       force_off
);
  logic     pressed;
  logic     no_pwr;
  logic     run_ok;
  btn_evt_t evt;

  assign no_pwr = st_no_power(sleep_st);
  assign run_ok = st_is_run(sleep_st) & ~stretch_active;

  pbe_sync_debounce #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEB_CYC    (DEB_CYC)
  ) u_deb (
    .clk    (clk),
    .rst    (rst),
    .clr    (no_pwr),
    .raw_n  (btn_raw_n),
    .pressed(pressed)
  );

  pbe_event_route u_route (
    .clk           (clk),
    .rst           (rst),
    .pressed       (pressed),
    .sleep_st      (sleep_st),
    .stretch_active(stretch_active),
    .sci_en        (sci_en),
    .btn_en        (btn_en),
    .btn_init_en   (btn_init_en),
    .glb_smi_en    (glb_smi_en),
    .evt           (evt)
  );

  pbe_long_press #(
    .LONG_CYC(LONG_CYC)
  ) u_hold (
    .clk      (clk),
    .rst      (rst),
    .pressed  (pressed),
    .run_ok   (run_ok),
    .force_off(force_off)
  );

  assign btn_level = pressed;
  assign smi_evt   = evt.smi;
  assign sci_evt   = evt.sci;
  assign wake_evt  = evt.wake;

  // R7: two cycles without main power leave every output quiet
  p_dead_unpowered_r7: assert property (@(posedge clk) disable iff (rst)
    $past(no_pwr) && $past(no_pwr, 2) |->
      !(btn_level | smi_evt | sci_evt | wake_evt | force_off));

  // R10: the cycle after reset every output is low
  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> !(btn_level | smi_evt | sci_evt | wake_evt | force_off));

endmodule

// File: tb/pwrbtn_event_ctrl_tb_top.sv
module pwrbtn_event_ctrl_tb_top;
  localparam int DEB  = 8;
  localparam int LONG = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw_n = 1'b1;
  logic [2:0] sleep_st = 3'd0;
  logic stretch_active = 1'b0;
  logic sci_en = 1'b0, btn_en = 1'b0, btn_init_en = 1'b0, glb_smi_en = 1'b0;
  logic btn_level, smi_evt, sci_evt, wake_evt, force_off;

  int total = 0, bad = 0, cyc = 0, base = 0;
  int n_smi, n_sci, n_wake, n_off, lvl_first, evt_first, off_first, lvl_pre;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwrbtn_event_ctrl #(.SYNC_STAGES(2), .DEB_CYC(DEB), .LONG_CYC(LONG)) dut_i (
    .clk(clk), .rst(rst), .btn_raw_n(btn_raw_n), .sleep_st(sleep_st),
    .stretch_active(stretch_active), .sci_en(sci_en), .btn_en(btn_en),
    .btn_init_en(btn_init_en), .glb_smi_en(glb_smi_en), .btn_level(btn_level),
    .smi_evt(smi_evt), .sci_evt(sci_evt), .wake_evt(wake_evt), .force_off(force_off));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    base = cyc; n_smi = 0; n_sci = 0; n_wake = 0; n_off = 0;
    lvl_first = -1; evt_first = -1; off_first = -1; lvl_pre = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      if (btn_level && lvl_first < 0) lvl_first = cyc - base;
      if ((smi_evt | sci_evt | wake_evt) && evt_first < 0) evt_first = cyc - base;
      if (btn_level && off_first < 0 && !force_off) lvl_pre++;
      n_smi += int'(smi_evt); n_sci += int'(sci_evt); n_wake += int'(wake_evt);
      if (force_off) begin
        n_off++;
        if (off_first < 0) off_first = cyc - base;
      end
    end
  endtask

  task automatic settle_release();
    btn_raw_n = 1'b1;
    tick(DEB + 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_mon();
    tick(3);
    chk(!(btn_level|smi_evt|sci_evt|wake_evt|force_off), "R10 outputs in reset",
        {btn_level,smi_evt,sci_evt,wake_evt,force_off}, 0);
    rst = 1'b0;
    tick(2);
    chk(!(btn_level|smi_evt|sci_evt|wake_evt|force_off), "R10 outputs after reset",
        {btn_level,smi_evt,sci_evt,wake_evt,force_off}, 0);

    // R3 / R1 / R4: sweep all enable combinations in S0
    for (int m = 0; m < 16; m++) begin
      int esci, esmi;
      {sci_en, btn_en, btn_init_en, glb_smi_en} = 4'(m);
      esci = int'(sci_en & btn_en);
      esmi = int'(~sci_en & glb_smi_en & (btn_en | btn_init_en));
      sleep_st = 3'd0;
      clear_mon();
      btn_raw_n = 1'b0;
      tick(DEB + 6);
      chk(lvl_first == DEB + 2, "R1 press filter delay", lvl_first, DEB + 2);
      chk(n_sci == esci, "R3 sci routing", n_sci, esci);
      chk(n_smi == esmi, "R3 smi routing", n_smi, esmi);
      chk(n_wake == 0, "R3 no wake in S0", n_wake, 0);
      if (esci + esmi > 0)
        chk(evt_first == DEB + 3, "R3 event cycle", evt_first, DEB + 3);
      clear_mon();
      btn_raw_n = 1'b1;
      for (int k = 1; k <= DEB + 6; k++) begin
        tick(1);
        if (k == DEB + 1) chk(btn_level == 1'b1, "R1 release not yet", int'(btn_level), 1);
        if (k == DEB + 2) chk(btn_level == 1'b0, "R1 release delay", int'(btn_level), 0);
      end
      chk(n_smi + n_sci + n_wake == 0, "R4 no event on release", n_smi + n_sci + n_wake, 0);
    end

    // R2: short glitches in both directions
    {sci_en, btn_en, btn_init_en, glb_smi_en} = 4'b1100;
    clear_mon();
    btn_raw_n = 1'b0; tick(DEB - 2);
    btn_raw_n = 1'b1; tick(DEB + 6);
    chk(lvl_first < 0, "R2 press glitch ignored", lvl_first, -1);
    chk(n_sci == 0, "R2 no event from glitch", n_sci, 0);
    btn_raw_n = 1'b0; tick(DEB + 6);
    clear_mon();
    btn_raw_n = 1'b1; tick(DEB - 2);
    btn_raw_n = 1'b0; tick(DEB + 6);
    chk(btn_level == 1'b1, "R2 release glitch ignored", int'(btn_level), 1);
    chk(n_sci == 0, "R4 held no repeat", n_sci, 0);
    settle_release();

    // R5: wake from every suspend state, with all notify enables on
    {sci_en, btn_en, btn_init_en, glb_smi_en} = 4'b1111;
    for (int s = 1; s <= 5; s++) begin
      sleep_st = 3'(s);
      clear_mon();
      btn_raw_n = 1'b0; tick(DEB + 6);
      chk(n_wake == 1, "R5 wake pulse", n_wake, 1);
      chk(evt_first == DEB + 3, "R5 wake cycle", evt_first, DEB + 3);
      chk(n_smi + n_sci == 0, "R5 no notify in suspend", n_smi + n_sci, 0);
      settle_release();
    end

    // R6: no wake during stretch
    sleep_st = 3'd4; stretch_active = 1'b1;
    clear_mon();
    btn_raw_n = 1'b0; tick(DEB + 6);
    chk(n_wake == 0, "R6 no wake in stretch", n_wake, 0);
    settle_release();
    stretch_active = 1'b0;

    // R7: no main power
    for (int s = 6; s <= 7; s++) begin
      sleep_st = 3'(s);
      clear_mon();
      btn_raw_n = 1'b0; tick(LONG + 20);
      chk(lvl_first < 0, "R7 level stays low", lvl_first, -1);
      chk(n_smi + n_sci + n_wake + n_off == 0, "R7 no events",
          n_smi + n_sci + n_wake + n_off, 0);
      btn_raw_n = 1'b1; tick(4);
    end
    sleep_st = 3'd0; tick(DEB + 6);

    // R8: long press in S0, single request
    {sci_en, btn_en, btn_init_en, glb_smi_en} = 4'b0000;
    clear_mon();
    btn_raw_n = 1'b0; tick(DEB + 2 + LONG + 100);
    chk(lvl_pre == LONG, "R8 hold length before off", lvl_pre, LONG);
    chk(n_off == 1, "R8 single off", n_off, 1);
    settle_release();

    // R9: short press then full press, timer restarts
    clear_mon();
    btn_raw_n = 1'b0; tick(DEB + 2 + LONG - 20);
    settle_release();
    chk(n_off == 0, "R9 short press no off", n_off, 0);
    clear_mon();
    btn_raw_n = 1'b0; tick(DEB + 2 + LONG + 10);
    chk(lvl_pre == LONG, "R9 restart full length", lvl_pre, LONG);
    settle_release();

    // R9: hold in suspend, then enter S0
    sleep_st = 3'd3;
    clear_mon();
    btn_raw_n = 1'b0; tick(DEB + 2 + 2 * LONG);
    chk(n_off == 0, "R9 no off in suspend", n_off, 0);
    chk(n_wake == 1, "R5 wake while held", n_wake, 1);
    sleep_st = 3'd0;
    clear_mon();
    tick(LONG + 10);
    chk(off_first == LONG, "R9 off after S0 entry", off_first, LONG);
    chk(n_off == 1, "R9 one off after entry", n_off, 1);
    settle_release();

    // R6: stretch in S0 holds timer, then release of stretch
    stretch_active = 1'b1;
    clear_mon();
    btn_raw_n = 1'b0; tick(DEB + 2 + 2 * LONG);
    chk(n_off == 0, "R6 timer held in stretch", n_off, 0);
    stretch_active = 1'b0;
    clear_mon();
    tick(LONG + 10);
    chk(off_first == LONG, "R6 off after stretch", off_first, LONG);
    settle_release();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule